// File: doc/BRIEF.md
# Serial Command Port with Buffer Flow Control

This block is the host-facing serial slave of a playback device. A host controller selects the port, clocks in a command byte and then any number of data bytes. While the command byte goes in, the block shifts a snapshot of the device status back out. On a write command the following bytes enter a 32-entry receive buffer, which the playback engine drains through a valid/ready stream. On a read command the following bytes are taken from a 32-entry transmit buffer, which the engine fills through a second valid/ready stream.

Flow control is done per byte with a ready/busy output. When a byte leaves the receive buffer full, or the transmit buffer has nothing for the next byte, the ready output drops. The host must then hold the serial clock high until ready returns. A host that keeps clocking anyway loses the ready bit in the status byte and raises an active-low interrupt. Bytes that arrive while the receive buffer is full are thrown away. The interrupt and the lost ready bit stay set until the core pulses a clear. All serial pins are brought into the system clock domain through two-flop synchronizers.

Back-pressure rules: the receive stream holds `rx_data` steady while `rx_valid` is high and `rx_ready` is low, and a byte leaves only on a cycle where both are high. The transmit stream takes a byte only on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low whenever the transmit buffer holds 32 bytes.

Top module: `spi_flow_slave`

## Requirements
- R1: After reset `ready_o` and `irq_n` are high, `rx_valid` is low and `tx_ready` is high. `spi_miso_oe` is low whenever the select pin has been high for three clock cycles, and high during a transaction.
- R2: The serial mode is clock-idle-high. MOSI is sampled on rising SCLK edges, MSB first, and MISO moves to its next bit on falling edges after the first falling edge of each byte. The first byte after select falls is the command: it appears on `cmd_op` with a one-cycle `cmd_strobe`.
- R3: During the command byte MISO returns a status byte captured when select falls. Bit 7 is `st_powerdown`, bit 6 is the ready bit (1 = no violation pending), bit 5 is the interrupt flag, bit 4 is set when the receive buffer is full, bits 3 to 1 are zero and bit 0 is `st_cmd_busy`.
- R4: When bit 6 of the command is 0, each following complete byte is written to the receive buffer. The bytes come out on the receive stream in arrival order, under the back-pressure rules above.
- R5: The receive buffer holds at most 32 bytes. In a write transaction `ready_o` is low while the buffer is full and returns high once a byte is drained. A byte completed while the buffer is full is discarded.
- R6: When bit 6 of the command is 1, each following byte on MISO is the next byte of the transmit buffer in the order it was pushed. MOSI bytes in a read transaction are not stored.
- R7: In a read transaction `ready_o` goes low after a byte completes if the transmit buffer is empty. It returns high when a byte arrives, and that byte is the next one sent.
- R8: A falling SCLK edge while `ready_o` is low clears the status ready bit and drives `irq_n` low. So does a byte discarded under R5.
- R9: `irq_n` and the cleared ready bit hold until a one-cycle `int_clr`. When a clear and a new event fall in the same cycle, the event wins.
- R10: Raising select mid-byte discards the partial byte. The first complete byte of the next selection is again treated as a command.
- R11: A change on a serial pin driven just after a clock edge takes effect in the block state on the third following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle high |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | MISO drive enable; low means high impedance |
| ready_o | output | 1 | High when the host may clock the next byte |
| irq_n | output | 1 | Active-low interrupt, meant to drive an open-drain pad |
| cmd_op | output | 8 | Last command byte received |
| cmd_strobe | output | 1 | One-cycle pulse when a command byte is latched |
| st_powerdown | input | 1 | Core power-down flag for the status byte |
| st_cmd_busy | input | 1 | Core command-busy flag for the status byte |
| int_clr | input | 1 | One-cycle clear of the interrupt and ready-bit violation |
| rx_data | output | 8 | Receive stream data |
| rx_valid | output | 1 | Receive stream valid |
| rx_ready | input | 1 | Receive stream ready from the engine |
| tx_data | input | 8 | Transmit stream data |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit stream ready |

## Verification
The two functions that can coincide are the core's interrupt clear and a new stall violation from the host clocking through a busy period. The bench fills the receive buffer until ready drops. It then drives a falling SCLK edge and places the `int_clr` pulse exactly on the third rising clock edge after that pin change, which is the edge where the synchronized violation is acted on. It judges the result by `irq_n` staying low afterwards, and also checks that an isolated clear raises it.

// File: rtl/spi_flow_pkg.sv
package spi_flow_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_t;

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic pwr_down,
    input logic rdy_ok,
    input logic int_pend,
    input logic rx_full,
    input logic cmd_busy
  );
    return {pwr_down, rdy_ok, int_pend, rx_full, 3'b000, cmd_busy};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[gi] <= RST_VAL;
          else        stg[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[gi] <= RST_VAL;
          else        stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];

endmodule

// File: rtl/spi_flow_slave.sv
module spi_flow_slave
  import spi_flow_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int READ_BIT  = 6,
  localparam int CNT_W    = $clog2(BUF_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              ready_o,
  output logic              irq_n,
  output logic [BYTE_W-1:0] cmd_op,
  output logic              cmd_strobe,
  input  logic              st_powerdown,
  input  logic              st_cmd_busy,
  input  logic              int_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready
);

  // synchronized pins: {select, clock, data}
  logic [2:0] pins_q;
  logic       cs_q, sclk_q, mosi_q;
  logic       cs_d, sclk_d;

  spi_pin_sync #(.W(3), .STAGES(2), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (pins_q)
  );

  assign {cs_q, sclk_q, mosi_q} = pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      cs_d   <= cs_q;
      sclk_d <= sclk_q;
    end
  end

  logic cs_fall, cs_rise, bit_rise, bit_fall;
  assign cs_fall  =  cs_d & ~cs_q;
  assign cs_rise  = ~cs_d &  cs_q;
  assign bit_rise = ~sclk_d &  sclk_q & ~cs_q;
  assign bit_fall =  sclk_d & ~sclk_q & ~cs_q;

  // serial engine state
  phase_t            phase;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] sh_in, sh_out;
  logic              rd_pend;
  logic              int_flag, rdy_bad;

  logic [BYTE_W-1:0] byte_val;
  logic              byte_done;
  assign byte_val  = {sh_in[BYTE_W-2:0], mosi_q};
  assign byte_done = bit_rise && (bit_cnt == 3'd7);

  // buffers
  logic [CNT_W-1:0]  rx_cnt, tx_cnt;
  logic [BYTE_W-1:0] tx_dout;
  logic              rx_full, tx_full, tx_empty;
  logic              rx_push, rx_pop, tx_push, tx_pop;
  logic              rx_try, overrun, violation, set_evt, stall;

  assign rx_full  = (rx_cnt == CNT_W'(BUF_DEPTH));
  assign tx_full  = (tx_cnt == CNT_W'(BUF_DEPTH));
  assign tx_empty = (tx_cnt == '0);

  assign rx_try  = byte_done && (phase == PH_WR);
  assign rx_push = rx_try && !rx_full;
  assign overrun = rx_try && rx_full;
  assign rx_pop  = rx_valid && rx_ready;

  assign tx_ready = !tx_full;
  assign tx_push  = tx_valid && !tx_full;
  assign tx_pop   = (phase == PH_RD) && rd_pend && !tx_empty && !byte_done;

  byte_fifo #(.WIDTH(BYTE_W), .DEPTH(BUF_DEPTH)) u_rx_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .din   (byte_val),
    .pop   (rx_pop),
    .dout  (rx_data),
    .count (rx_cnt)
  );

  byte_fifo #(.WIDTH(BYTE_W), .DEPTH(BUF_DEPTH)) u_tx_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .din   (tx_data),
    .pop   (tx_pop),
    .dout  (tx_dout),
    .count (tx_cnt)
  );

  assign rx_valid = (rx_cnt != '0);

  // stall: write side waits for room, read side waits for data
  assign stall = !cs_q &&
                 (((phase == PH_WR) && rx_full) ||
                  ((phase == PH_RD) && rd_pend && tx_empty));

  assign violation = bit_fall && stall;
  assign set_evt   = violation || overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      bit_cnt    <= '0;
      sh_in      <= '0;
      sh_out     <= '0;
      cmd_op     <= '0;
      cmd_strobe <= 1'b0;
      rd_pend    <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      if (cs_rise) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        rd_pend <= 1'b0;
      end else begin
        if (cs_fall) begin
          sh_out  <= pack_status(st_powerdown, !rdy_bad, int_flag, rx_full, st_cmd_busy);
          phase   <= PH_CMD;
          bit_cnt <= '0;
        end
        if (tx_pop) begin
          sh_out  <= tx_dout;
          rd_pend <= 1'b0;
        end else if (bit_fall && (bit_cnt != 3'd0)) begin
          sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
        end
        if (bit_rise) begin
          sh_in   <= byte_val;
          bit_cnt <= bit_cnt + 3'd1;
          if (byte_done) begin
            case (phase)
              PH_CMD: begin
                cmd_op     <= byte_val;
                cmd_strobe <= 1'b1;
                if (byte_val[READ_BIT]) begin
                  phase   <= PH_RD;
                  rd_pend <= 1'b1;
                end else begin
                  phase <= PH_WR;
                end
              end
              PH_RD:   rd_pend <= 1'b1;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // interrupt and ready-bit violation, event beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_flag <= 1'b0;
      rdy_bad  <= 1'b0;
    end else begin
      if (set_evt)      int_flag <= 1'b1;
      else if (int_clr) int_flag <= 1'b0;
      if (violation)    rdy_bad  <= 1'b1;
      else if (int_clr) rdy_bad  <= 1'b0;
    end
  end

  assign spi_miso    = sh_out[BYTE_W-1];
  assign spi_miso_oe = !cs_q;
  assign ready_o     = !stall;
  assign irq_n       = !int_flag;

endmodule

// File: rtl/spi_flow_slave_chk.sv
module spi_flow_slave_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_miso_oe,
  input logic          irq_n,
  input logic          int_clr,
  input logic          set_evt,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [7:0]    rx_data,
  input logic          cmd_strobe,
  input logic [CW-1:0] rx_cnt
);

  // R1: select held high for three cycles means MISO released
  a_r1_miso_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);

  // R2: command strobe lasts one cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  // R4: stalled receive stream keeps its data
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R5: receive occupancy never passes the depth
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  // R9: interrupt holds without a clear
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !int_clr) |=> !irq_n);

  // R9: a new event wins over a same-cycle clear
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> !irq_n);

endmodule

bind spi_flow_slave spi_flow_slave_chk #(.DEPTH(BUF_DEPTH), .CW(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_miso_oe (spi_miso_oe),
  .irq_n       (irq_n),
  .int_clr     (int_clr),
  .set_evt     (set_evt),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .cmd_strobe  (cmd_strobe),
  .rx_cnt      (rx_cnt)
);

// File: tb/sim_spi_flow_slave.sv
module sim_spi_flow_slave;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe, ready_o, irq_n, cmd_strobe;
  logic [7:0] cmd_op, rx_data, tx_data = 8'h00;
  logic       st_powerdown = 1'b0, st_cmd_busy = 1'b0, int_clr = 1'b0;
  logic       rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_flow_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .ready_o(ready_o), .irq_n(irq_n), .cmd_op(cmd_op), .cmd_strobe(cmd_strobe),
    .st_powerdown(st_powerdown), .st_cmd_busy(st_cmd_busy), .int_clr(int_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic desel();
    spi_cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      spi_sclk = 1'b0;
      spi_mosi = o[b];
      wait_clk(6);
      i[b] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(6);
    end
  endtask

  task automatic pulse_clr();
    int_clr = 1'b1;
    wait_clk(1);
    int_clr = 1'b0;
    wait_clk(2);
  endtask

  task automatic push_tx(input logic [7:0] d);
    chk("R6 tx_ready", tx_ready, 1);
    tx_data  = d;
    tx_valid = 1'b1;
    wait_clk(1);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(input string req, input logic [7:0] exp);
    chk({req, " rx_valid"}, rx_valid, 1);
    chk({req, " rx_data"}, rx_data, exp);
    rx_ready = 1'b1;
    wait_clk(1);
    rx_ready = 1'b0;
  endtask

  task automatic fill_rx(input logic [7:0] cmd, input logic [7:0] base);
    logic [7:0] s;
    sel();
    xbyte(cmd, s);
    for (int k = 0; k < 32; k++) begin
      xbyte(base + 8'(k), s);
      if (k == 30) chk("R5 ready before full", ready_o, 1);
    end
    wait_clk(2);
    chk("R5 ready low when full", ready_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", ready_o, 1);
    chk("R1 irq after reset", irq_n, 1);
    chk("R1 miso released", spi_miso_oe, 0);
    chk("R1 rx_valid after reset", rx_valid, 0);
    chk("R1 tx_ready after reset", tx_ready, 1);
  endtask

  task automatic t_write();
    logic [7:0] s;
    st_powerdown = 1'b1;
    st_cmd_busy  = 1'b1;
    sel();
    chk("R1 miso driven", spi_miso_oe, 1);
    xbyte(8'h05, s);
    chk("R3 status byte", s, 8'hC1);
    chk("R2 command latched", cmd_op, 8'h05);
    xbyte(8'hA5, s);
    xbyte(8'h3C, s);
    xbyte(8'h0F, s);
    desel();
    chk("R1 miso released after", spi_miso_oe, 0);
    st_powerdown = 1'b0;
    st_cmd_busy  = 1'b0;
    wait_clk(4);
    chk("R4 data held under back-pressure", rx_data, 8'hA5);
    pop_rx("R4 order", 8'hA5);
    pop_rx("R4 order", 8'h3C);
    pop_rx("R4 order", 8'h0F);
    chk("R4 drained", rx_valid, 0);
  endtask

  task automatic t_full();
    fill_rx(8'h01, 8'h40);
    chk("R5 no irq on clean stall", irq_n, 1);
    pop_rx("R5 first", 8'h40);
    wait_clk(2);
    chk("R5 ready back after drain", ready_o, 1);
    desel();
    for (int k = 1; k < 32; k++) pop_rx("R4 full order", 8'h40 + 8'(k));
    chk("R4 empty after drain", rx_valid, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] s;
    fill_rx(8'h01, 8'h80);
    xbyte(8'hEE, s);
    wait_clk(2);
    chk("R8 irq on clocking through stall", irq_n, 0);
    desel();
    for (int k = 0; k < 32; k++) pop_rx("R5 kept bytes", 8'h80 + 8'(k));
    chk("R5 overrun byte dropped", rx_valid, 0);
    sel();
    xbyte(8'h00, s);
    desel();
    chk("R8 status ready bit cleared", s[6], 0);
    chk("R8 status interrupt bit", s[5], 1);
    wait_clk(20);
    chk("R9 irq holds", irq_n, 0);
    pulse_clr();
    chk("R9 irq released by clear", irq_n, 1);
    sel();
    xbyte(8'h00, s);
    desel();
    chk("R9 status after clear", s, 8'h40);
  endtask

  task automatic t_read();
    logic [7:0] d;
    push_tx(8'h3C);
    push_tx(8'h5A);
    sel();
    xbyte(8'h40, d);
    wait_clk(2);
    chk("R7 ready with data waiting", ready_o, 1);
    xbyte(8'hFF, d);
    chk("R6 first read byte", d, 8'h3C);
    xbyte(8'h00, d);
    chk("R6 second read byte", d, 8'h5A);
    wait_clk(2);
    chk("R7 ready low when empty", ready_o, 0);
    push_tx(8'h99);
    wait_clk(3);
    chk("R7 ready back on data", ready_o, 1);
    xbyte(8'h12, d);
    chk("R7 late byte sent next", d, 8'h99);
    desel();
    chk("R6 mosi not stored", rx_valid, 0);
    chk("R6 no irq on clean read", irq_n, 1);
  endtask

  task automatic t_underrun();
    logic [7:0] d;
    sel();
    xbyte(8'h41, d);
    wait_clk(2);
    chk("R7 ready low on empty read", ready_o, 0);
    xbyte(8'h00, d);
    wait_clk(2);
    chk("R8 irq on invalid read", irq_n, 0);
    desel();
    pulse_clr();
    chk("R9 irq cleared", irq_n, 1);
  endtask

  task automatic t_abort();
    logic [7:0] s;
    sel();
    xbyte(8'h02, s);
    for (int b = 0; b < 3; b++) begin
      spi_sclk = 1'b0;
      spi_mosi = 1'b1;
      wait_clk(6);
      spi_sclk = 1'b1;
      wait_clk(6);
    end
    desel();
    chk("R10 partial byte dropped", rx_valid, 0);
    sel();
    xbyte(8'h07, s);
    chk("R10 new command after abort", cmd_op, 8'h07);
    xbyte(8'h11, s);
    desel();
    pop_rx("R10 data after abort", 8'h11);
    chk("R10 single byte stored", rx_valid, 0);
  endtask

  task automatic t_coincide();
    fill_rx(8'h03, 8'hC0);
    chk("R9 irq clear before race", irq_n, 1);
    spi_mosi = 1'b0;
    spi_sclk = 1'b0;
    wait_clk(2);
    int_clr = 1'b1;
    wait_clk(1);
    int_clr = 1'b0;
    wait_clk(2);
    chk("R11 event wins over same-cycle clear", irq_n, 0);
    spi_sclk = 1'b1;
    wait_clk(6);
    desel();
    pulse_clr();
    chk("R9 lone clear works", irq_n, 1);
    for (int k = 0; k < 32; k++) pop_rx("R4 race drain", 8'hC0 + 8'(k));
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write();
    t_full();
    t_overrun();
    t_read();
    t_underrun();
    t_abort();
    t_coincide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule